// File: doc/BRIEF.md
# Shared Integer/Float Register Operand Steering

This block connects the floating-point side of an execution stage to two register files that it owns: an integer file of XLEN-wide registers and a separate 64-bit floating-point file. A mode input chooses where floating-point operands come from and where results go. When the mode is clear, the three source operands are read from the floating-point file. Any result is written there, and the floating-point state is marked dirty for that cycle. When the mode is set, the same register indices address the integer file instead.

In integer-register mode, the operand precision decides how the integer registers are viewed. Narrow operands are the low bits of one register. Narrow results are sign-extended to XLEN when they are written back. A double on a 64-bit core uses one whole register. On a 32-bit core a double occupies an even/odd register pair, and an odd base index is reported as an illegal operand. Integer register zero reads as zero and ignores writes, also when it is the base of a pair. Reads are combinational and writes take effect on the rising clock edge.

Top module: `sri_steer`

## Requirements
- R1: With `finx_en` low, each of `op1`..`op3` equals the full 64-bit floating-point register at its source index, whatever the precision.
- R2: With `finx_en` high, precision code 0 (half) gives the low 16 bits of the integer register at the source index, zero-extended to 64 bits. Code 1 (single) gives the low 32 bits, zero-extended.
- R3: With `finx_en` high, XLEN=64 and precision code 2 or 3 (double), the operand is the whole 64-bit integer register.
- R4: With `finx_en` high, XLEN=32 and double precision, an even index n gives {x[n+1], x[n]} as the operand.
- R5: With `finx_en` high, XLEN=32 and double precision, `op_illegal` is asserted if any source index is odd, or if `wr_en` is high and `rd` is odd. An odd source reads as zero, and no register is written in that cycle. `op_illegal` is never asserted in any other case.
- R6: Integer register 0 reads as zero and is never written. A double pair based at index 0 reads as 64 zero bits, and a double write to that pair changes neither register 0 nor register 1.
- R7: In integer-register mode, a half result is written to x[rd] sign-extended from bit 15 to XLEN.
- R8: In integer-register mode, a single result is written to x[rd] sign-extended from bit 31 to XLEN.
- R9: In integer-register mode, a double result goes unchanged to x[rd] when XLEN=64. When XLEN=32 and rd is even, bits 31:0 go to x[rd] and bits 63:32 go to x[rd+1].
- R10: With `finx_en` low, a write stores `wr_data` into floating-point register `rd` and raises `fs_dirty` in that same cycle. With `finx_en` high, `fs_dirty` stays low and the floating-point file is not changed.
- R11: The three source ports follow identical steering rules, so equal indices give equal operands.
- R12: After reset, every register in both files holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears both files |
| finx_en | input | 1 | 1 = float operands live in the integer file |
| prec | input | 2 | 0 half, 1 single, 2 or 3 double |
| rs1 | input | AW | First source index |
| rs2 | input | AW | Second source index |
| rs3 | input | AW | Third source index |
| rd | input | AW | Destination index |
| wr_en | input | 1 | Write the result this cycle |
| wr_data | input | 64 | Result value (narrow results in the low bits) |
| op1 | output | 64 | First operand |
| op2 | output | 64 | Second operand |
| op3 | output | 64 | Third operand |
| op_illegal | output | 1 | Odd index used for a double pair |
| fs_dirty | output | 1 | A floating-point file write occurs this cycle |

## Verification
A register corrupted by a write to the wrong register, a wrong sign extension or a lost pair half stays hidden until that index is read again. For that reason, every write phase is followed by a full read sweep of all indices, at all three precisions, on all three ports. A wrong value therefore shows on an operand port within one sweep, at most a few hundred cycles later. Errors in routing, illegal flagging and the dirty flag are combinational and show in the same cycle as the offending input. Both XLEN variants receive identical stimulus, so a pair-handling fault shows as a divergence from the arithmetic model in the 32-bit instance.

// File: rtl/sri_pkg.sv
package sri_pkg;
    localparam int FLEN    = 64;
    localparam int NSRC    = 3;
    localparam logic [1:0] PREC_HALF   = 2'd0;
    localparam logic [1:0] PREC_SINGLE = 2'd1;

    function automatic logic is_double(input logic [1:0] p);
        return p[1];
    endfunction
endpackage

// File: rtl/sri_xrf.sv
module sri_xrf #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_lo,
    input  logic [AW-1:0]   widx_lo,
    input  logic [XLEN-1:0] wdat_lo,
    input  logic            we_hi,
    input  logic [AW-1:0]   widx_hi,
    input  logic [XLEN-1:0] wdat_hi,
    input  logic [AW-1:0]   ridx [sri_pkg::NSRC],
    output logic [XLEN-1:0] rlo  [sri_pkg::NSRC],
    output logic [XLEN-1:0] rhi  [sri_pkg::NSRC]
);
    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] mem;
    } xrf_s;

    xrf_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_lo && widx_lo != '0) st_d.mem[widx_lo] = wdat_lo;
        if (we_hi && widx_hi != '0) st_d.mem[widx_hi] = wdat_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < sri_pkg::NSRC; g++) begin : g_rd
        logic [AW-1:0] odd_idx;
        assign odd_idx = ridx[g] | AW'(1);
        assign rlo[g]  = (ridx[g] == '0) ? '0 : st_q.mem[ridx[g]];
        assign rhi[g]  = (ridx[g] == '0) ? '0 : st_q.mem[odd_idx];
    end
endmodule

// File: rtl/sri_frf.sv
module sri_frf #(
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG),
    localparam int W  = sri_pkg::FLEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [W-1:0]  wdat,
    input  logic [AW-1:0] ridx [sri_pkg::NSRC],
    output logic [W-1:0]  rdat [sri_pkg::NSRC]
);
    typedef struct packed {
        logic [NREG-1:0][W-1:0] mem;
    } frf_s;

    frf_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.mem[widx] = wdat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < sri_pkg::NSRC; g++) begin : g_rd
        assign rdat[g] = st_q.mem[ridx[g]];
    end
endmodule

// File: rtl/sri_src.sv
module sri_src #(
    parameter int XLEN = 64,
    parameter int AW   = 5,
    localparam int W   = sri_pkg::FLEN
) (
    input  logic            finx_en,
    input  logic [1:0]      prec,
    input  logic [AW-1:0]   idx,
    input  logic [XLEN-1:0] xlo,
    input  logic [XLEN-1:0] xhi,
    input  logic [W-1:0]    fdat,
    output logic [W-1:0]    op,
    output logic            bad
);
    always_comb begin
        op  = '0;
        bad = 1'b0;
        if (!finx_en) begin
            op = fdat;
        end else if (prec == sri_pkg::PREC_HALF) begin
            op = W'(xlo[15:0]);
        end else if (prec == sri_pkg::PREC_SINGLE) begin
            op = W'(xlo[31:0]);
        end else if (XLEN == 64) begin
            op = W'(xlo);
        end else if (idx[0]) begin
            bad = 1'b1;
        end else begin
            op = {xhi[31:0], xlo[31:0]};
        end
    end
endmodule

// File: rtl/sri_wb.sv
module sri_wb #(
    parameter int XLEN = 64,
    parameter int AW   = 5,
    localparam int W   = sri_pkg::FLEN
) (
    input  logic            wr_en,
    input  logic            finx_en,
    input  logic [1:0]      prec,
    input  logic [AW-1:0]   rd,
    input  logic [W-1:0]    wr_data,
    output logic            x_we_lo,
    output logic            x_we_hi,
    output logic [AW-1:0]   x_idx_hi,
    output logic [XLEN-1:0] x_dat_lo,
    output logic [XLEN-1:0] x_dat_hi,
    output logic            f_we,
    output logic            bad_rd
);
    logic pair;

    assign pair     = (XLEN == 32) && sri_pkg::is_double(prec);
    assign x_idx_hi = rd | AW'(1);

    always_comb begin
        x_we_lo  = 1'b0;
        x_we_hi  = 1'b0;
        x_dat_lo = '0;
        x_dat_hi = XLEN'(wr_data[63:32]);
        f_we     = wr_en && !finx_en;
        bad_rd   = 1'b0;
        if (wr_en && finx_en) begin
            if (prec == sri_pkg::PREC_HALF)
                x_dat_lo = XLEN'($signed(wr_data[15:0]));
            else if (prec == sri_pkg::PREC_SINGLE)
                x_dat_lo = XLEN'($signed(wr_data[31:0]));
            else
                x_dat_lo = XLEN'(wr_data);
            if (pair && rd[0]) begin
                bad_rd = 1'b1;
            end else if (rd != '0) begin
                x_we_lo = 1'b1;
                x_we_hi = pair;
            end
        end
    end
endmodule

// File: rtl/sri_steer.sv
module sri_steer #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          finx_en,
    input  logic [1:0]    prec,
    input  logic [AW-1:0] rs1,
    input  logic [AW-1:0] rs2,
    input  logic [AW-1:0] rs3,
    input  logic [AW-1:0] rd,
    input  logic          wr_en,
    input  logic [63:0]   wr_data,
    output logic [63:0]   op1,
    output logic [63:0]   op2,
    output logic [63:0]   op3,
    output logic          op_illegal,
    output logic          fs_dirty
);
    localparam int NS = sri_pkg::NSRC;

    logic [AW-1:0]   ridx [NS];
    logic [XLEN-1:0] xlo  [NS];
    logic [XLEN-1:0] xhi  [NS];
    logic [63:0]     fdat [NS];
    logic [63:0]     ops  [NS];
    logic [NS-1:0]   src_bad;

    logic            wx_lo, wx_hi, wf, bad_rd;
    logic            x_we_lo, x_we_hi, f_we;
    logic [AW-1:0]   x_idx_hi;
    logic [XLEN-1:0] x_dat_lo, x_dat_hi;

    assign ridx[0] = rs1;
    assign ridx[1] = rs2;
    assign ridx[2] = rs3;

    sri_xrf #(.XLEN(XLEN), .NREG(NREG)) u_xrf (
        .clk(clk), .rst_n(rst_n),
        .we_lo(x_we_lo), .widx_lo(rd), .wdat_lo(x_dat_lo),
        .we_hi(x_we_hi), .widx_hi(x_idx_hi), .wdat_hi(x_dat_hi),
        .ridx(ridx), .rlo(xlo), .rhi(xhi)
    );

    sri_frf #(.NREG(NREG)) u_frf (
        .clk(clk), .rst_n(rst_n),
        .we(f_we), .widx(rd), .wdat(wr_data),
        .ridx(ridx), .rdat(fdat)
    );

    for (genvar g = 0; g < NS; g++) begin : g_src
        sri_src #(.XLEN(XLEN), .AW(AW)) u_src (
            .finx_en(finx_en), .prec(prec), .idx(ridx[g]),
            .xlo(xlo[g]), .xhi(xhi[g]), .fdat(fdat[g]),
            .op(ops[g]), .bad(src_bad[g])
        );
    end

    sri_wb #(.XLEN(XLEN), .AW(AW)) u_wb (
        .wr_en(wr_en), .finx_en(finx_en), .prec(prec), .rd(rd),
        .wr_data(wr_data),
        .x_we_lo(wx_lo), .x_we_hi(wx_hi), .x_idx_hi(x_idx_hi),
        .x_dat_lo(x_dat_lo), .x_dat_hi(x_dat_hi),
        .f_we(wf), .bad_rd(bad_rd)
    );

    assign op_illegal = (|src_bad) || bad_rd;
    assign x_we_lo    = wx_lo && !op_illegal;
    assign x_we_hi    = wx_hi && !op_illegal;
    assign f_we       = wf;
    assign fs_dirty   = f_we;

    assign op1 = ops[0];
    assign op2 = ops[1];
    assign op3 = ops[2];
endmodule

// File: rtl/sri_steer_chk.sv
module sri_steer_chk #(
    parameter int XLEN = 64,
    parameter int AW   = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          finx_en,
    input logic [1:0]    prec,
    input logic [AW-1:0] rs1,
    input logic [AW-1:0] rs2,
    input logic [AW-1:0] rd,
    input logic          wr_en,
    input logic [63:0]   wr_data,
    input logic [63:0]   op1,
    input logic [63:0]   op2,
    input logic [63:0]   op3,
    input logic          op_illegal,
    input logic          fs_dirty,
    input logic          x_we_lo,
    input logic          x_we_hi,
    input logic          f_we
);
    AST_FS_DIRTY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !finx_en |-> fs_dirty);                                  // R10
    AST_FS_DIRTY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        finx_en |-> !fs_dirty);                                           // R10
    AST_ONE_FILE: assert property (@(posedge clk) disable iff (!rst_n)
        !((x_we_lo || x_we_hi) && f_we));                                 // R10
    AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        finx_en && prec == 2'd0 |-> op1[63:16] == '0 && op2[63:16] == '0 && op3[63:16] == '0); // R2
    AST_SINGLE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        finx_en && prec == 2'd1 |-> op1[63:32] == '0 && op3[63:32] == '0); // R2
    AST_X0_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        finx_en && !prec[1] && rs1 == '0 |-> op1 == '0);                  // R6
    AST_X0_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        finx_en && prec[1] && rs2 == '0 |-> op2 == '0);                   // R6
    AST_ILLEGAL_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> finx_en && prec[1] && XLEN == 32);                 // R5
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> !x_we_lo && !x_we_hi);                             // R5
    AST_PORTS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rs1 == rs2 |-> op1 == op2);                                       // R11
    AST_SINGLE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && finx_en && prec == 2'd1 && rd != '0 && !op_illegal
        |=> !(finx_en && prec == 2'd1 && rs1 == $past(rd) && !$past(rst_n) == 1'b0)
            || op1 == {32'd0, $past(wr_data[31:0])});                    // R8
endmodule

bind sri_steer sri_steer_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .finx_en(finx_en), .prec(prec),
    .rs1(rs1), .rs2(rs2), .rd(rd), .wr_en(wr_en), .wr_data(wr_data),
    .op1(op1), .op2(op2), .op3(op3), .op_illegal(op_illegal),
    .fs_dirty(fs_dirty), .x_we_lo(x_we_lo), .x_we_hi(x_we_hi), .f_we(f_we)
);

// File: tb/sim_sri_steer.sv
module sim_sri_steer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        finx;
    logic [1:0]  prec;
    logic [4:0]  rs1, rs2, rs3, rd;
    logic        we;
    logic [63:0] wd;

    logic [63:0] a1, a2, a3, b1, b2, b3;
    logic        a_ill, b_ill, a_dirty, b_dirty;

    logic [63:0] fr  [32];
    logic [63:0] x64 [32];
    logic [31:0] x32 [32];

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sri_steer #(.XLEN(64)) u0 (
        .clk(clk), .rst_n(rst_n), .finx_en(finx), .prec(prec),
        .rs1(rs1), .rs2(rs2), .rs3(rs3), .rd(rd), .wr_en(we), .wr_data(wd),
        .op1(a1), .op2(a2), .op3(a3), .op_illegal(a_ill), .fs_dirty(a_dirty)
    );

    sri_steer #(.XLEN(32)) u1 (
        .clk(clk), .rst_n(rst_n), .finx_en(finx), .prec(prec),
        .rs1(rs1), .rs2(rs2), .rs3(rs3), .rd(rd), .wr_en(we), .wr_data(wd),
        .op1(b1), .op2(b2), .op3(b3), .op_illegal(b_ill), .fs_dirty(b_dirty)
    );

    function automatic logic [63:0] pat(input int n);
        logic [31:0] u, v;
        u = 32'(n) * 32'h9E3779B9;
        v = ~(32'(n) * 32'h85EBCA6B);
        return {u, v};
    endfunction

    function automatic logic [63:0] expect_op(input bit is32, input logic [4:0] i);
        if (!finx) return fr[i];
        if (prec == 2'd0) return is32 ? {48'd0, x32[i][15:0]} : {48'd0, x64[i][15:0]};
        if (prec == 2'd1) return is32 ? {32'd0, x32[i]} : {32'd0, x64[i][31:0]};
        if (!is32) return x64[i];
        if (i[0] || i == 5'd0) return 64'd0;
        return {x32[i + 5'd1], x32[i]};
    endfunction

    function automatic string tag_of(input bit is32, input logic [4:0] i, input string ph);
        if (finx && i == 5'd0) return {"R6/", ph};
        if (!finx) return {"R1/", ph};
        if (!prec[1]) return {"R2/", ph};
        return is32 ? {"R4/", ph} : {"R3/", ph};
    endfunction

    task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input string ph);
        bit ill32;
        #5;
        cmp(tag_of(0, rs1, ph), a1, expect_op(0, rs1));
        cmp({"R11/", tag_of(0, rs2, ph)}, a2, expect_op(0, rs2));
        cmp({"R11/", tag_of(0, rs3, ph)}, a3, expect_op(0, rs3));
        cmp(tag_of(1, rs1, ph), b1, expect_op(1, rs1));
        cmp({"R11/", tag_of(1, rs2, ph)}, b2, expect_op(1, rs2));
        cmp({"R11/", tag_of(1, rs3, ph)}, b3, expect_op(1, rs3));
        ill32 = finx && prec[1] && (rs1[0] || rs2[0] || rs3[0] || (we && rd[0]));
        cmp("R5 illegal xlen64", {63'd0, a_ill}, 64'd0);
        cmp("R5 illegal xlen32", {63'd0, b_ill}, {63'd0, ill32});
        cmp("R10 dirty xlen64", {63'd0, a_dirty}, {63'd0, we && !finx});
        cmp("R10 dirty xlen32", {63'd0, b_dirty}, {63'd0, we && !finx});
        if (we) begin
            if (!finx) begin
                fr[rd] = wd;
            end else begin
                if (rd != 5'd0) begin
                    if (prec == 2'd0)      x64[rd] = 64'($signed(wd[15:0]));
                    else if (prec == 2'd1) x64[rd] = 64'($signed(wd[31:0]));
                    else                   x64[rd] = wd;
                end
                if (rd != 5'd0 && !ill32) begin
                    if (prec == 2'd0)      x32[rd] = 32'($signed(wd[15:0]));
                    else if (prec == 2'd1) x32[rd] = wd[31:0];
                    else begin
                        x32[rd]        = wd[31:0];
                        x32[rd + 5'd1] = wd[63:32];
                    end
                end
            end
        end
    endtask

    task automatic read_sweep(input bit mode, input string ph);
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 32; i++) begin
                @(negedge clk);
                finx = mode; prec = 2'(p); we = 1'b0;
                rs1 = 5'(i); rs2 = 5'(i + 5); rs3 = 5'(i + 11);
                apply(ph);
            end
        end
    endtask

    task automatic write_sweep(input bit mode, input logic [1:0] pr, input int seed, input string ph);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            finx = mode; prec = pr; we = 1'b1; rd = 5'(i);
            rs1 = 5'd2; rs2 = 5'd4; rs3 = 5'd6;
            wd = pat(i + seed);
            apply(ph);
        end
        @(negedge clk);
        we = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            fr[i] = '0; x64[i] = '0; x32[i] = '0;
        end
        rst_n = 1'b0; finx = 1'b0; prec = 2'd0; we = 1'b0; wd = '0;
        rs1 = '0; rs2 = '0; rs3 = '0; rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_sweep(1'b0, "R12 reset fp");
        read_sweep(1'b1, "R12 reset int");
        write_sweep(1'b0, 2'd2, 100, "R10 fp write");
        read_sweep(1'b0, "R1 fp read");
        read_sweep(1'b1, "R10 int untouched");
        write_sweep(1'b1, 2'd0, 200, "R7 half write");
        read_sweep(1'b1, "R7 half readback");
        write_sweep(1'b1, 2'd1, 300, "R8 single write");
        read_sweep(1'b1, "R8 single readback");
        write_sweep(1'b1, 2'd2, 400, "R9 double write");
        read_sweep(1'b1, "R9 double readback");
        read_sweep(1'b0, "R10 fp untouched");
        write_sweep(1'b1, 2'd3, 500, "R9 double code3 write");
        read_sweep(1'b1, "R6 R9 final int");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule